// File: doc/BRIEF.md
# Taskfile register-list sequencer

This block takes a command packet that already sits in a local byte memory and replays its taskfile register list toward a disk interface. A start pulse supplies the packet base address. The block then reads the header through a one-cycle-latency read port and checks the control flags. It walks the (value, address) byte pairs from offset 16 and issues one register write strobe per entry that is not skipped.

When the list completes, the block reports the outcome on a response-byte writeback port aimed at offset 0 of the packet. It raises a one-cycle done pulse, with an interrupt flag when the packet asks for one. If the packet announces a data phase and the list completed cleanly, it also raises a data-phase request that carries the scatter-gather list pointer. Moving the data and decoding the disk command are left to neighbouring logic.

The length byte bounds the list, so a packet that never marks its last entry cannot run past its own end. Such a packet ends with an error code.

Top module: `tf_list_seq`

## Requirements
- R1: While reset is held and after it is released with no start, reg_wr, mem_rd, resp_we, dp_req, done and irq are all low.
- R2: Control byte (offset 2) bit 0 is the valid flag. If it is clear, no register write is issued, the response byte 0x02 is written to the base address and done pulses.
- R3: Register entries begin at offset 16 as a value byte followed by an address byte. Each entry is written in list order with reg_addr equal to address bits 4:0 and reg_data equal to the value byte.
- R4: An entry whose address byte has bit 5 set produces no register write, and the walk continues with the next entry.
- R5: An address byte with bit 7 set ends the list after that entry. The response byte 0x01 is then written to the base address, and done pulses in the next cycle.
- R6: If control bit 2 is set and the list ended cleanly, dp_req pulses together with done and never in the same cycle as a register write. dp_ptr then carries bytes 8 to 11 as a little-endian 32-bit value. No dp_req is raised on any error.
- R7: irq pulses with done exactly when control bit 3 is set, whatever the outcome.
- R8: The list may occupy only bytes below (L+2)*8, where L is the length byte at offset 3. If no end flag appears there, the response byte 0x04 is written, done pulses and no further register write or memory read follows. A length of 0 gives this error with no register write at all.
- R9: A start pulse that arrives while a packet is in progress is ignored. It does not change the addresses used or the results produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (accepted only when idle) |
| base_addr | input | AW | Byte address of the packet in local memory |
| mem_rd | output | 1 | Read request to packet memory |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| reg_wr | output | 1 | Taskfile register write strobe |
| reg_addr | output | 5 | Taskfile register address |
| reg_data | output | 8 | Taskfile register value |
| dp_req | output | 1 | Data-phase request pulse |
| dp_ptr | output | 32 | Scatter-gather list pointer |
| resp_we | output | 1 | Response byte write strobe |
| resp_addr | output | AW | Response byte address (packet base) |
| resp_data | output | 8 | Response code: 0x01 done, 0x02 invalid, 0x04 length overrun |
| done | output | 1 | Packet finished pulse |
| irq | output | 1 | Completion interrupt request, with done |

## Verification
A corrupted byte index shows up as a wrong register address or value on the very next write strobe. It can also appear as a write the list never asked for, so an ordered queue of expected events catches it within one entry. A wrong idea of the list bound or the end flag changes the response code and the cycle of done. The bench also plants a trap entry just past the length limit, so an over-long walk produces an unexpected write. Stale header fields, such as the control byte or pointer from a previous packet, surface at done as a wrong irq, a missing or spurious data-phase request, or a wrong pointer.

// File: rtl/tf_list_seq.sv
module tf_list_seq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          reg_wr,
  output logic [4:0]    reg_addr,
  output logic [7:0]    reg_data,
  output logic          dp_req,
  output logic [31:0]   dp_ptr,
  output logic          resp_we,
  output logic [AW-1:0] resp_addr,
  output logic [7:0]    resp_data,
  output logic          done,
  output logic          irq
);
  localparam int IW = 12;
  localparam logic [7:0] CODE_OK   = 8'h01;
  localparam logic [7:0] CODE_INV  = 8'h02;
  localparam logic [7:0] CODE_OVER = 8'h04;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_FIN} st_t;
  st_t state;

  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [7:0]    ctrl, len, val, code;
  logic [31:0]   sg;
  logic [IW-1:0] limit;
  logic          wr_slot;

  assign limit = ({4'b0, len} + IW'(2)) << 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      base_q <= '0;
      ctrl   <= '0;
      len    <= '0;
      val    <= '0;
      code   <= '0;
      sg     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          base_q <= base_addr;
          idx    <= IW'(2);
          state  <= S_RD;
        end
        S_RD: state <= S_CAP;
        S_CAP: begin
          state <= S_RD;
          if (idx == IW'(2)) begin
            ctrl <= mem_rdata;
            idx  <= IW'(3);
            if (!mem_rdata[0]) begin
              code  <= CODE_INV;
              state <= S_FIN;
            end
          end else if (idx == IW'(3)) begin
            len <= mem_rdata;
            idx <= IW'(8);
          end else if (idx < IW'(16)) begin
            sg <= {mem_rdata, sg[31:8]};
            if (idx == IW'(11)) begin
              idx <= IW'(16);
              if (len == 8'd0) begin
                code  <= CODE_OVER;
                state <= S_FIN;
              end
            end else begin
              idx <= idx + IW'(1);
            end
          end else if (!idx[0]) begin
            val <= mem_rdata;
            idx <= idx + IW'(1);
          end else if (mem_rdata[7]) begin
            code  <= CODE_OK;
            state <= S_FIN;
          end else if (idx + IW'(1) >= limit) begin
            code  <= CODE_OVER;
            state <= S_FIN;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state == S_RD);
  assign mem_addr  = base_q + AW'(idx);
  assign wr_slot   = (state == S_CAP) && (idx >= IW'(16)) && idx[0];
  assign reg_wr    = wr_slot && !mem_rdata[5];
  assign reg_addr  = mem_rdata[4:0];
  assign reg_data  = val;
  assign done      = (state == S_FIN);
  assign resp_we   = done;
  assign resp_addr = base_q;
  assign resp_data = code;
  assign dp_req    = done && (code == CODE_OK) && ctrl[2];
  assign dp_ptr    = sg;
  assign irq       = done && ctrl[3];

  // R2
  valid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ctrl[0]);
  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(mem_rd));
  // R5
  done_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == S_CAP);
  // R6
  dp_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_req |-> (!reg_wr && done));
  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!reg_wr && !mem_rd && !done));
  // R9
  hold_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != S_IDLE) |=> $stable(base_q));
endmodule

// File: tb/tb_tf_list_seq.sv
module tb_tf_list_seq;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;
  logic          reg_wr;
  logic [4:0]    reg_addr;
  logic [7:0]    reg_data;
  logic          dp_req;
  logic [31:0]   dp_ptr;
  logic          resp_we;
  logic [AW-1:0] resp_addr;
  logic [7:0]    resp_data;
  logic          done;
  logic          irq;

  always #2 clk = ~clk;

  tf_list_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .dp_req(dp_req), .dp_ptr(dp_ptr),
    .resp_we(resp_we), .resp_addr(resp_addr), .resp_data(resp_data),
    .done(done), .irq(irq)
  );

  logic [7:0] mem [4096];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int nchk = 0;
  int nbad = 0;
  logic [47:0] expq[$];
  string       tagq[$];
  logic [7:0]  pv [32];
  logic [7:0]  pa [32];
  int          np;

  task automatic push(input logic [3:0] k, input logic [11:0] a, input logic [31:0] d, input string t);
    expq.push_back({k, a, d});
    tagq.push_back(t);
  endtask

  task automatic check(input bit ok, input string t, input logic [47:0] got, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic see(input logic [47:0] got);
    logic [47:0] e;
    string t;
    if (expq.size() == 0) begin
      check(1'b0, "unexpected event R3", got, 48'h0);
    end else begin
      e = expq.pop_front();
      t = tagq.pop_front();
      check(got == e, t, got, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_wr)  see({4'd1, 12'(reg_addr), 32'(reg_data)});
    if (resp_we) see({4'd2, 12'(resp_addr), 32'(resp_data)});
    if (dp_req)  see({4'd3, 12'h0, dp_ptr});
    if (done)    see({4'd4, 12'h0, 32'(irq)});
  end

  task automatic set_pair(input int k, input logic [7:0] v, input logic [7:0] a);
    pv[k] = v;
    pa[k] = a;
    if (k + 1 > np) np = k + 1;
  endtask

  task automatic run_pkt(input logic [11:0] base, input logic [7:0] ctrl, input logic [7:0] len,
                         input logic [31:0] sg, input bit poke, input string t);
    int limit;
    logic [7:0] res;
    logic [7:0] v, a;
    limit = (int'(len) + 2) * 8;
    for (int i = 0; i < limit + 8; i++) mem[base + 12'(i)] = 8'h00;
    mem[base] = 8'h55;
    mem[base + 12'd2] = ctrl;
    mem[base + 12'd3] = len;
    mem[base + 12'd4] = 8'hAA;
    for (int i = 0; i < 4; i++) mem[base + 12'(8 + i)] = sg[8*i +: 8];
    for (int p = 16; p < limit; p += 2) begin
      int k = (p - 16) / 2;
      mem[base + 12'(p)]     = (k < np) ? pv[k] : 8'h00;
      mem[base + 12'(p + 1)] = (k < np) ? pa[k] : 8'h20;
    end
    mem[base + 12'(limit)]     = 8'hFF;
    mem[base + 12'(limit + 1)] = 8'h1F;
    if (!ctrl[0]) begin
      res = 8'h02;
    end else begin
      res = 8'h04;
      for (int p = 16; p < limit && res == 8'h04; p += 2) begin
        v = mem[base + 12'(p)];
        a = mem[base + 12'(p + 1)];
        if (!a[5]) push(4'd1, 12'(a[4:0]), 32'(v), t);
        if (a[7]) res = 8'h01;
      end
    end
    push(4'd2, base, 32'(res), t);
    if (res == 8'h01 && ctrl[2]) push(4'd3, 12'h0, sg, "R6");
    push(4'd4, 12'h0, 32'(ctrl[3]), "R7");
    @(negedge clk);
    start = 1'b1;
    base_addr = base;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      base_addr = base + 12'h040;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, {t, " all expected events seen"}, 48'(expq.size()), 48'h0);
    expq.delete();
    tagq.delete();
    np = 0;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    np = 0;
    repeat (4) @(negedge clk);
    // R1
    check({reg_wr, mem_rd, resp_we, dp_req, done, irq} == 6'b0, "R1 in reset",
          48'({reg_wr, mem_rd, resp_we, dp_req, done, irq}), 48'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({reg_wr, mem_rd, resp_we, dp_req, done, irq} == 6'b0, "R1 after reset",
          48'({reg_wr, mem_rd, resp_we, dp_req, done, irq}), 48'h0);

    // R3 short address form with a skipped entry, data phase and irq
    set_pair(0, 8'hE0, 8'h16); set_pair(1, 8'h08, 8'h12); set_pair(2, 8'h11, 8'h13);
    set_pair(3, 8'h22, 8'h14); set_pair(4, 8'h33, 8'h15); set_pair(5, 8'h00, 8'h0E);
    set_pair(6, 8'h00, 8'h20); set_pair(7, 8'hC8, 8'h97);
    run_pkt(12'h100, 8'h0D, 8'd2, 32'h8765_4321, 1'b0, "R3");

    // R3 long address form, no data phase, no irq
    set_pair(0, 8'h40, 8'h16); set_pair(1, 8'h01, 8'h12); set_pair(2, 8'h02, 8'h13);
    set_pair(3, 8'h03, 8'h14); set_pair(4, 8'h04, 8'h15); set_pair(5, 8'h10, 8'h12);
    set_pair(6, 8'h20, 8'h13); set_pair(7, 8'h30, 8'h14); set_pair(8, 8'h40, 8'h15);
    set_pair(9, 8'h00, 8'h0E); set_pair(10, 8'h00, 8'h20); set_pair(11, 8'h25, 8'h97);
    run_pkt(12'h200, 8'h01, 8'd3, 32'hDEAD_BEEF, 1'b0, "R3");

    // R2 invalid packet
    set_pair(0, 8'h99, 8'h97);
    run_pkt(12'h300, 8'h0C, 8'd2, 32'h1111_2222, 1'b0, "R2");

    // R8 list without end flag
    set_pair(0, 8'h01, 8'h01); set_pair(1, 8'h02, 8'h02);
    set_pair(2, 8'h03, 8'h03); set_pair(3, 8'h04, 8'h04);
    run_pkt(12'h400, 8'h05, 8'd1, 32'h3333_4444, 1'b0, "R8");

    // R8 zero length
    set_pair(0, 8'h77, 8'h97);
    run_pkt(12'h500, 8'h0D, 8'd0, 32'h5555_6666, 1'b0, "R8");

    // R5 end flag early in a longer packet
    set_pair(0, 8'h40, 8'h16); set_pair(1, 8'hCA, 8'h97);
    run_pkt(12'h600, 8'h05, 8'd3, 32'h0BAD_F00D, 1'b0, "R5");

    // R4 end entry that is also skipped
    set_pair(0, 8'h5A, 8'h13); set_pair(1, 8'h77, 8'hB7);
    run_pkt(12'h700, 8'h0D, 8'd2, 32'hCAFE_0001, 1'b0, "R4");

    // R9 start while busy
    set_pair(0, 8'hE0, 8'h16); set_pair(1, 8'h08, 8'h12);
    set_pair(2, 8'h00, 8'h20); set_pair(3, 8'hC8, 8'h97);
    run_pkt(12'h800, 8'h0D, 8'd1, 32'h0123_4567, 1'b1, "R9");

    finish_run();
  end
endmodule